// File: doc/BRIEF.md
# Sequential Signed Restoring Divider

This block divides one two's complement integer by another over several clock cycles. A single-cycle `start` pulse captures the dividend and the divisor. The block then runs one restoring iteration per clock and reports a signed quotient and remainder with a one-cycle `done` pulse. The quotient is truncated toward zero. The remainder is zero or carries the sign of the dividend. The operand width is the parameter `WIDTH`.

The dividend is sign-extended into a double-width register pair: an upper partial-remainder half and a lower dividend/quotient half. Each iteration does the following:

- It shifts the pair left by one bit as a single unit.
- It subtracts the divisor when the dividend and the divisor have equal signs, and adds it when their signs differ.
- It keeps the trial result when the result stays on the dividend's side of zero. Otherwise it restores the shifted value.
- It writes the new quotient bit into bit 0 of the lower half.

A trial result of exactly zero counts as kept only when the dividend is non-negative, or when no unprocessed dividend bits remain set. This rule keeps truncation exact for negative dividends. The quotient magnitude is negated at the end when the operand signs differ.

A zero divisor is caught at `start` and returns in the next cycle with the divide-by-zero flag set. The single unrepresentable case is the most negative dividend divided by -1. That case is only flagged and is not saturated.

Top module: `sdiv_restoring`

## Requirements
- R1: While reset is asserted, and after it is released with no start, `busy`, `done`, `div_zero` and `overflow` are 0 and `quotient` and `remainder` are 0.
- R2: For a non-zero divisor, excluding the overflow case, `quotient` equals the dividend divided by the divisor truncated toward zero, as a `WIDTH`-bit two's complement value. In the same result, `div_zero` and `overflow` are 0.
- R3: For the same operands as R2, `remainder` equals dividend minus quotient times divisor. It is zero or has the sign of the dividend.
- R4: A start with a non-zero divisor is accepted on the rising edge where `start` is 1 and `busy` is 0. `busy` is 1 for the next `WIDTH` cycles. `done` is 1 in the cycle that begins `WIDTH` rising edges after the accepting edge, and `busy` is 0 in that cycle.
- R5: `done` is 1 for exactly one cycle per operation. `busy` and `done` are never 1 together.
- R6: A `start` pulse while `busy` is 1 has no effect. The running operation ends at its original time with its original result, and no extra `done` follows.
- R7: A divisor of 0 leaves `busy` at 0. `done` and `div_zero` are 1 in the cycle right after the accepting edge, with `quotient` and `remainder` 0.
- R8: The most negative dividend divided by -1 sets `overflow` with `done` after the normal latency. `quotient` is the most negative value (the wrapped result) and `remainder` is 0.
- R9: `quotient`, `remainder`, `div_zero` and `overflow` keep their values until the next operation completes. That completion replaces all four, so flags from a previous result are cleared.
- R10: The captured divisor stays unchanged while `busy` is 1. The iteration counter starts at `WIDTH` and falls by one per busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Starts an operation when the block is not busy |
| dividend | input | WIDTH | Two's complement dividend, sampled with start |
| divisor | input | WIDTH | Two's complement divisor, sampled with start |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle pulse: result outputs are new |
| quotient | output | WIDTH | Signed quotient, truncated toward zero |
| remainder | output | WIDTH | Signed remainder, sign of the dividend |
| div_zero | output | 1 | Last result came from a zero divisor |
| overflow | output | 1 | Last result was the most negative value divided by -1 |

## Verification
The bench builds the block twice. The first copy uses `WIDTH=4`, where all 256 operand pairs are run and compared against the language's truncating division and modulo. That run reaches every sign combination, every zero-trial corner on a negative dividend, both extreme divisors and the overflow pair. The second copy uses `WIDTH=8` with pseudo-random pairs plus extreme values, which exercises the widened trial adder and the counter at a size where the partial remainder can reach twice the divisor. Directed scenarios on the 4-bit copy cover start while busy, holding of results and clearing of flags across operations.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } sdiv_state_e;

endpackage

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl
  import sdiv_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             zero_div,
  output logic             busy,
  output logic             done,
  output logic             load,
  output logic             zload,
  output logic             step_en,
  output logic             last_step,
  output logic [CNT_W-1:0] cnt
);

  sdiv_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    load    = 1'b0;
    zload   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          if (zero_div) begin
            zload  = 1'b1;
            done_d = 1'b1;
          end else begin
            load    = 1'b1;
            state_d = ST_RUN;
            cnt_d   = CNT_W'(WIDTH);
          end
        end
      end
      ST_RUN: begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (state_q == ST_RUN);
  assign done      = done_q;
  assign step_en   = busy;
  assign last_step = busy && (cnt_q == CNT_W'(1));
  assign cnt       = cnt_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> !done);

  // R5
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);

  // R10
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != CNT_W'(1)) |=> busy && (cnt == CNT_W'($past(cnt) - 1'b1)));

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && !zero_div |=> busy && (cnt == CNT_W'(WIDTH)));

endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
  parameter int WIDTH = 8,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] r_cur,
  input  logic [WIDTH-1:0] q_cur,
  input  logic [WIDTH-1:0] v_cur,
  input  logic             dsign,
  input  logic [CNT_W-1:0] cnt,
  output logic [WIDTH-1:0] r_nxt,
  output logic [WIDTH-1:0] q_nxt
);

  localparam int TW = WIDTH + 2;

  logic [WIDTH:0]   r_sh;
  logic [WIDTH-1:0] q_sh;
  logic [TW-1:0]    r_ext, v_ext, trial;
  logic             subtract, pend, accept;

  always_comb begin
    r_sh     = {r_cur, q_cur[WIDTH-1]};
    q_sh     = {q_cur[WIDTH-2:0], 1'b0};
    r_ext    = {r_sh[WIDTH], r_sh};
    v_ext    = {{2{v_cur[WIDTH-1]}}, v_cur};
    subtract = (dsign == v_cur[WIDTH-1]);
    trial    = subtract ? (r_ext - v_ext) : (r_ext + v_ext);

    pend = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      if (q_sh[i] && ((i + int'(cnt)) > WIDTH)) begin
        pend = 1'b1;
      end
    end

    if (trial == '0) begin
      accept = !dsign || !pend;
    end else begin
      accept = (trial[TW-1] == dsign);
    end

    r_nxt = accept ? trial[WIDTH-1:0] : r_sh[WIDTH-1:0];
    q_nxt = {q_sh[WIDTH-1:1], accept};
  end

endmodule

// File: rtl/sdiv_sign_fix.sv
module sdiv_sign_fix #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q_raw,
  input  logic             negate,
  output logic [WIDTH-1:0] q_out
);

  always_comb begin
    q_out = negate ? (~q_raw + 1'b1) : q_raw;
  end

endmodule

// File: rtl/sdiv_restoring.sv
module sdiv_restoring #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             div_zero,
  output logic             overflow
);

  localparam int               CNT_W    = $clog2(WIDTH + 1);
  localparam logic [WIDTH-1:0] MOST_NEG = {1'b1, {(WIDTH-1){1'b0}}};

  logic [1:0] rst_pipe_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic             load, zload, step_en, last_step, zero_div;
  logic [CNT_W-1:0] cnt;

  assign zero_div = (divisor == '0);

  sdiv_ctrl #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .start     (start),
    .zero_div  (zero_div),
    .busy      (busy),
    .done      (done),
    .load      (load),
    .zload     (zload),
    .step_en   (step_en),
    .last_step (last_step),
    .cnt       (cnt)
  );

  logic [WIDTH-1:0] v_q, v_d, r_q, r_d, q_q, q_d;
  logic             dsign_q, dsign_d, ovf_pend_q, ovf_pend_d;
  logic [WIDTH-1:0] quo_q, quo_d, rem_q, rem_d;
  logic             dz_q, dz_d, ovf_q, ovf_d;
  logic [WIDTH-1:0] r_step, q_step, q_fixed;

  sdiv_step #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_step (
    .r_cur (r_q),
    .q_cur (q_q),
    .v_cur (v_q),
    .dsign (dsign_q),
    .cnt   (cnt),
    .r_nxt (r_step),
    .q_nxt (q_step)
  );

  sdiv_sign_fix #(.WIDTH(WIDTH)) u_fix (
    .q_raw  (q_step),
    .negate (dsign_q ^ v_q[WIDTH-1]),
    .q_out  (q_fixed)
  );

  always_comb begin
    v_d        = v_q;
    r_d        = r_q;
    q_d        = q_q;
    dsign_d    = dsign_q;
    ovf_pend_d = ovf_pend_q;
    quo_d      = quo_q;
    rem_d      = rem_q;
    dz_d       = dz_q;
    ovf_d      = ovf_q;
    if (load) begin
      v_d        = divisor;
      r_d        = {WIDTH{dividend[WIDTH-1]}};
      q_d        = dividend;
      dsign_d    = dividend[WIDTH-1];
      ovf_pend_d = (dividend == MOST_NEG) && (&divisor);
    end
    if (step_en) begin
      r_d = r_step;
      q_d = q_step;
    end
    if (last_step) begin
      quo_d = q_fixed;
      rem_d = r_step;
      dz_d  = 1'b0;
      ovf_d = ovf_pend_q;
    end
    if (zload) begin
      quo_d = '0;
      rem_d = '0;
      dz_d  = 1'b1;
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      v_q        <= '0;
      r_q        <= '0;
      q_q        <= '0;
      dsign_q    <= 1'b0;
      ovf_pend_q <= 1'b0;
      quo_q      <= '0;
      rem_q      <= '0;
      dz_q       <= 1'b0;
      ovf_q      <= 1'b0;
    end else begin
      v_q        <= v_d;
      r_q        <= r_d;
      q_q        <= q_d;
      dsign_q    <= dsign_d;
      ovf_pend_q <= ovf_pend_d;
      quo_q      <= quo_d;
      rem_q      <= rem_d;
      dz_q       <= dz_d;
      ovf_q      <= ovf_d;
    end
  end

  assign quotient  = quo_q;
  assign remainder = rem_q;
  assign div_zero  = dz_q;
  assign overflow  = ovf_q;

  // R10
  divisor_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy |=> $stable(v_q));

  // R7
  zero_out_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done && div_zero |-> (quotient == '0) && (remainder == '0) && !overflow);

  // R3
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    done && !div_zero && (remainder != '0) |-> (remainder[WIDTH-1] == dsign_q));

  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !done |=> done || ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

  // R6
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy && start |=> !div_zero || !done);

endmodule

// File: tb/sdiv_restoring_bench.sv
module sdiv_restoring_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic       s4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic       busy4, done4, dz4, ov4;
  logic [3:0] q4, r4;

  logic       s8 = 1'b0;
  logic [7:0] a8 = '0, b8 = '0;
  logic       busy8, done8, dz8, ov8;
  logic [7:0] q8, r8;

  sdiv_restoring #(.WIDTH(4)) u_sdiv_restoring (
    .clk(clk), .rst_n(rst_n), .start(s4), .dividend(a4), .divisor(b4),
    .busy(busy4), .done(done4), .quotient(q4), .remainder(r4),
    .div_zero(dz4), .overflow(ov4));

  sdiv_restoring #(.WIDTH(8)) u_sdiv_restoring_w8 (
    .clk(clk), .rst_n(rst_n), .start(s8), .dividend(a8), .divisor(b8),
    .busy(busy8), .done(done8), .quotient(q8), .remainder(r8),
    .div_zero(dz8), .overflow(ov8));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic judge(input int n, input int ai, input int bi,
                       input int q, input int r, input bit dz, input bit ov,
                       input bit busy_end, input bit busy_first, input int lat);
    int mask, mn, eq, er;
    string tag;
    mask = (1 << n) - 1;
    mn   = -(1 << (n - 1));
    tag  = $sformatf("w%0d %0d/%0d", n, ai, bi);
    if (bi == 0) begin
      chk(dz == 1'b1 && ov == 1'b0, "R7", {tag, " flags dz"}, int'(dz), 1);
      chk(q == 0 && r == 0, "R7", {tag, " zero result"}, q | r, 0);
      chk(lat == 1 && !busy_first, "R7", {tag, " latency"}, lat, 1);
    end else if (ai == mn && bi == -1) begin
      chk(ov == 1'b1 && dz == 1'b0, "R8", {tag, " overflow flag"}, int'(ov), 1);
      chk(q == (mn & mask) && r == 0, "R8", {tag, " wrapped quotient"}, q, mn & mask);
      chk(lat == n + 1, "R4", {tag, " latency"}, lat, n + 1);
    end else begin
      eq = ai / bi;
      er = ai % bi;
      chk(q == (eq & mask), "R2", {tag, " quotient"}, q, eq & mask);
      chk(r == (er & mask), "R3", {tag, " remainder"}, r, er & mask);
      chk(dz == 1'b0 && ov == 1'b0, "R2", {tag, " flags clear"}, int'({dz, ov}), 0);
      chk(lat == n + 1, "R4", {tag, " done latency"}, lat, n + 1);
      chk(busy_first == 1'b1, "R4", {tag, " busy after start"}, int'(busy_first), 1);
    end
    chk(busy_end == 1'b0, "R5", {tag, " busy low with done"}, int'(busy_end), 0);
  endtask

  task automatic op4(input logic [3:0] a, input logic [3:0] b);
    int  lat;
    bit  bf;
    @(negedge clk);
    s4 = 1'b1; a4 = a; b4 = b;
    @(negedge clk);
    s4 = 1'b0; lat = 1; bf = busy4;
    while (!done4 && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    judge(4, int'($signed(a)), int'($signed(b)), int'(q4), int'(r4), dz4, ov4,
          busy4, bf, lat);
  endtask

  task automatic op8(input logic [7:0] a, input logic [7:0] b);
    int  lat;
    bit  bf;
    @(negedge clk);
    s8 = 1'b1; a8 = a; b8 = b;
    @(negedge clk);
    s8 = 1'b0; lat = 1; bf = busy8;
    while (!done8 && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    judge(8, int'($signed(a)), int'($signed(b)), int'(q8), int'(r8), dz8, ov8,
          busy8, bf, lat);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy4 && !done4 && !dz4 && !ov4 && q4 == 0 && r4 == 0, "R1",
        "w4 outputs in reset", int'({busy4, done4, dz4, ov4}), 0);
    chk(!busy8 && !done8 && !dz8 && !ov8 && q8 == 0 && r8 == 0, "R1",
        "w8 outputs in reset", int'({busy8, done8, dz8, ov8}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy4 && !done4 && q4 == 0 && r4 == 0, "R1",
        "w4 outputs after release", int'({busy4, done4}), 0);
  endtask

  task automatic t_exhaustive4;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        op4(4'(a), 4'(b));
      end
    end
  endtask

  task automatic t_random8;
    op8(8'h80, 8'h01);
    op8(8'h80, 8'hFF);
    op8(8'h7F, 8'h80);
    op8(8'h80, 8'h80);
    op8(8'h81, 8'h7F);
    op8(8'h9C, 8'h00);
    for (int i = 0; i < 300; i++) begin
      op8(8'($urandom), 8'($urandom));
    end
  endtask

  // R6: start pulse while busy must not disturb the running division
  task automatic t_ignore_start;
    int lat;
    bit extra;
    @(negedge clk);
    s4 = 1'b1; a4 = 4'd7; b4 = 4'd2;
    @(negedge clk);
    s4 = 1'b0; lat = 1;
    @(negedge clk);
    lat++;
    s4 = 1'b1; a4 = 4'h8; b4 = 4'd0;
    @(negedge clk);
    lat++;
    s4 = 1'b0;
    while (!done4 && lat < 64) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5, "R6", "done time unchanged", lat, 5);
    chk(q4 == 4'd3 && r4 == 4'd1 && !dz4, "R6", "original result kept",
        int'({q4, r4}), int'({4'd3, 4'd1}));
    extra = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done4 || busy4) extra = 1'b1;
    end
    chk(!extra, "R6", "no second operation", int'(extra), 0);
  endtask

  // R9: results hold between operations, flags replaced on completion
  task automatic t_hold;
    logic [3:0] qh, rh;
    bit moved;
    op4(4'd7, 4'hE);
    qh = q4; rh = r4;
    moved = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (q4 != qh || r4 != rh || done4) moved = 1'b1;
    end
    chk(!moved, "R9", "result held while idle", int'({q4, r4}), int'({qh, rh}));
    chk(q4 == 4'hD && r4 == 4'd1, "R9", "held 7/-2 value", int'({q4, r4}),
        int'({4'hD, 4'd1}));
    op4(4'd5, 4'd0);
    chk(dz4 == 1'b1, "R9", "div_zero set", int'(dz4), 1);
    op4(4'd5, 4'd2);
    chk(dz4 == 1'b0, "R9", "div_zero cleared by next result", int'(dz4), 0);
    op4(4'h8, 4'hF);
    chk(ov4 == 1'b1, "R9", "overflow set", int'(ov4), 1);
    op4(4'h8, 4'd3);
    chk(ov4 == 1'b0, "R9", "overflow cleared by next result", int'(ov4), 0);
  endtask

  // R5: done lasts one cycle
  task automatic t_pulse;
    op4(4'hB, 4'd3);
    @(negedge clk);
    chk(!done4 && !busy4, "R5", "done single cycle", int'({done4, busy4}), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not end actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pulse();
    t_exhaustive4();
    t_ignore_start();
    t_hold();
    t_random8();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule